// File: doc/BRIEF.md
# System-Management Memory Window Controller

This block owns the configuration state that decides which memory a processor access reaches when it falls into one of the protected system-management regions. Software programs two byte-wide control registers and one 16-bit extended-size register through a small write port. Every access presents an address and a management-mode bit. The block then answers combinationally with exactly one region select and, where needed, a translated RAM address.

There are three protected regions. The legacy window covers 0xA0000 to 0xBFFFF. The high alias is a 128 KiB window at 0xFEDA0000 that reaches the same RAM as the legacy window. The top segment sits just below the top of low memory, which is an input. Accesses outside management mode that land in an active top segment are sunk: reads return all ones and writes are dropped. A lock bit freezes both control registers until reset.

The extended segment size is a parameter in MiB. Software discovers it by writing the query code 0xFFFF to the extended-size register and reading it back. A parameter value above the configured maximum stops elaboration.

Top module: `smm_access_ctl`

## Requirements
- R1: After reset, control register 0 reads 0x00, control register 1 reads 0x00, and the extended-size register reads 0xFFFF when the extended size is nonzero. With these reset values every access gets selDefault.
- R2: Control register 0 has open at bit 0, lock at bit 2 and global enable at bit 3. Control register 1 has segment enable at bit 0, size code at bits 2:1 and high enable at bit 7. While unlocked, the writable masks are 0x0D and 0x87, and all other bits read 0. A write that sets lock stores open as 0. From then on, writes to registers 0 and 1 change nothing until reset.
- R3: A non-management access in [0xA0000, 0xC0000) selects selLowRam when open=1 and high enable=0. Otherwise it gets selDefault.
- R4: A non-management access in [0xFEDA0000, 0xFEDC0000) selects selHighRam when open=1 and high enable=1. In that case ramAddr = address - 0xFEDA0000 + 0xA0000. Otherwise the access gets selDefault.
- R5: When global enable=1, a management access selects selLowRam in the legacy window if high enable=0, and selHighRam in the high alias if high enable=1. Without that condition it gets the same result as a non-management access.
- R6: The top segment is active only when both segment enable and global enable are 1. Size codes 0, 1 and 2 give 1, 2 and 8 MiB. Code 3 gives the extended size in MiB.
- R7: An active top segment spans [topLowMem - size, topLowMem). There, a non-management access gets selBlackhole and a management access gets selTsegRam. The segment takes priority over the other windows.
- R8: A write to register 2 of the value 0xFFFF stores the extended size when that size is nonzero. Any other value is stored as written and reads back unchanged.
- R9: Exactly one of selDefault, selLowRam, selHighRam, selTsegRam and selBlackhole is 1 at all times. selBlackhole is never 1 for a management access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Register select: 0 control, 1 extended control, 2 extended size |
| cfgWrData | input | 16 | Write data; registers 0 and 1 use bits 7:0 |
| cfgRdData | output | 16 | Combinational read data of the selected register |
| topLowMem | input | 32 | Byte address of the top of low memory |
| accAddr | input | 32 | Access address |
| accSmm | input | 1 | Access is made in management mode |
| selDefault | output | 1 | Ordinary system decode |
| selLowRam | output | 1 | Legacy window served from RAM |
| selHighRam | output | 1 | High alias served from RAM at ramAddr |
| selTsegRam | output | 1 | Top segment served from RAM |
| selBlackhole | output | 1 | Reads all ones, writes dropped |
| ramAddr | output | 32 | RAM address for the access |

## Verification
The bench builds the block with an extended size of 3 MiB. This value differs from every fixed size code, so a decode of code 3 as 1, 2 or 8 MiB moves the segment base and shows up at the boundary addresses. It also makes the query readback distinguishable from 0xFFFF and from the default. The top of low memory is held at 128 MiB, so each size code has a distinct first blackhole address and a distinct last default address below it.

// File: rtl/smm_pkg.sv
package smm_pkg;

  localparam logic [1:0] CFG_CTL  = 2'd0;
  localparam logic [1:0] CFG_EXT  = 2'd1;
  localparam logic [1:0] CFG_SIZE = 2'd2;

  localparam int OPEN_BIT  = 0;
  localparam int LOCK_BIT  = 2;
  localparam int GEN_BIT   = 3;
  localparam int TEN_BIT   = 0;
  localparam int CODE_LSB  = 1;
  localparam int HEN_BIT   = 7;

  localparam logic [7:0] CTL_MASK_OPEN = 8'h0D;
  localparam logic [7:0] EXT_MASK_OPEN = 8'h87;

  localparam logic [15:0] SIZE_QUERY = 16'hFFFF;

  typedef struct packed {
    logic        open;
    logic        globalEn;
    logic        highEn;
    logic [15:0] tsegMib;
  } smmView_t;

  typedef struct packed {
    logic isDefault;
    logic isLow;
    logic isHigh;
    logic isTseg;
    logic isBlack;
  } smmSel_t;

endpackage

// File: rtl/smm_cfg_ctrl.sv
module smm_cfg_ctrl
  import smm_pkg::*;
#(
  parameter int unsigned EXT_TSEG_MIB = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgAddr,
  input  logic [15:0] cfgWrData,
  output logic [15:0] cfgRdData,
  output smmView_t    view
);

  localparam logic [15:0] EXT_SIZE = 16'(EXT_TSEG_MIB);
  localparam logic [15:0] SIZE_RST = (EXT_TSEG_MIB > 0) ? SIZE_QUERY : 16'h0000;

  logic [7:0]  ctlQ, extQ, ctlNext, extNext, ctlMask, extMask;
  logic [15:0] sizeQ, sizeNext;
  logic        locked;

  assign locked  = ctlQ[LOCK_BIT];
  assign ctlMask = locked ? 8'h00 : CTL_MASK_OPEN;
  assign extMask = locked ? 8'h00 : EXT_MASK_OPEN;

  always_comb begin
    ctlNext = (ctlQ & ~ctlMask) | (cfgWrData[7:0] & ctlMask);
    if (ctlNext[LOCK_BIT]) ctlNext[OPEN_BIT] = 1'b0;
    extNext = (extQ & ~extMask) | (cfgWrData[7:0] & extMask);
    if ((EXT_TSEG_MIB > 0) && (cfgWrData == SIZE_QUERY)) sizeNext = EXT_SIZE;
    else sizeNext = cfgWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ  <= 8'h00;
      extQ  <= 8'h00;
      sizeQ <= SIZE_RST;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        CFG_CTL:  ctlQ  <= ctlNext;
        CFG_EXT:  extQ  <= extNext;
        CFG_SIZE: sizeQ <= sizeNext;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (cfgAddr)
      CFG_CTL:  cfgRdData = {8'h00, ctlQ};
      CFG_EXT:  cfgRdData = {8'h00, extQ};
      CFG_SIZE: cfgRdData = sizeQ;
      default:  cfgRdData = 16'h0000;
    endcase
  end

  always_comb begin
    view.open     = ctlQ[OPEN_BIT];
    view.globalEn = ctlQ[GEN_BIT];
    view.highEn   = extQ[HEN_BIT];
    view.tsegMib  = 16'h0000;
    if (extQ[TEN_BIT] && ctlQ[GEN_BIT]) begin
      case (extQ[CODE_LSB +: 2])
        2'd0:    view.tsegMib = 16'd1;
        2'd1:    view.tsegMib = 16'd2;
        2'd2:    view.tsegMib = 16'd8;
        default: view.tsegMib = EXT_SIZE;
      endcase
    end
  end

  // R2: the lock bit never falls between resets
  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

  // R2: locked registers ignore writes
  a_r2_locked_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (locked && cfgWrEn && cfgAddr != CFG_SIZE) |=> ($stable(ctlQ) && $stable(extQ)));

  // R2: a locked controller never reports open
  a_r2_lock_closes: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == CFG_CTL && cfgWrData[LOCK_BIT]) |=> !view.open);

  generate
    if (EXT_TSEG_MIB > 0) begin : g_query
      // R8: query code is answered with the extended size
      a_r8_query_answer: assert property (@(posedge clk) disable iff (!rstN)
        (cfgWrEn && cfgAddr == CFG_SIZE && cfgWrData == SIZE_QUERY) |=> (sizeQ == EXT_SIZE));
    end
  endgenerate

endmodule

// File: rtl/smm_addr_decode.sv
module smm_addr_decode
  import smm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [31:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [31:0] HIGH_BASE = 32'hFEDA_0000,
  parameter logic [31:0] WIN_BYTES = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  smmView_t          view,
  input  logic [ADDR_W-1:0] topLowMem,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accSmm,
  output smmSel_t           sel,
  output logic [ADDR_W-1:0] ramAddr
);

  localparam int unsigned SW = ADDR_W + 17;
  localparam logic [ADDR_W-1:0] LOW_A  = ADDR_W'(LOW_BASE);
  localparam logic [ADDR_W-1:0] HIGH_A = ADDR_W'(HIGH_BASE);
  localparam logic [ADDR_W-1:0] WIN_A  = ADDR_W'(WIN_BYTES);

  logic [SW-1:0]     addrX, topX, sizeX;
  logic              inTseg, inLow, inHigh, lowOk, highOk;
  logic [ADDR_W-1:0] lowOff, highOff;

  assign addrX   = SW'(accAddr);
  assign topX    = SW'(topLowMem);
  assign sizeX   = SW'(view.tsegMib) << 20;
  assign inTseg  = (view.tsegMib != 16'h0000) && (addrX < topX) && ((addrX + sizeX) >= topX);
  assign lowOff  = accAddr - LOW_A;
  assign highOff = accAddr - HIGH_A;
  assign inLow   = (accAddr >= LOW_A) && (lowOff < WIN_A);
  assign inHigh  = (accAddr >= HIGH_A) && (highOff < WIN_A);
  assign lowOk   = !view.highEn && (view.open || (accSmm && view.globalEn));
  assign highOk  = view.highEn && (view.open || (accSmm && view.globalEn));

  always_comb begin
    sel = '0;
    if (inTseg) begin
      sel.isTseg  = accSmm;
      sel.isBlack = !accSmm;
    end else if (inHigh && highOk) begin
      sel.isHigh = 1'b1;
    end else if (inLow && lowOk) begin
      sel.isLow = 1'b1;
    end else begin
      sel.isDefault = 1'b1;
    end
  end

  assign ramAddr = sel.isHigh ? (highOff + LOW_A) : accAddr;

  // R9: exactly one region select
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(sel) == 1);

  // R9: management accesses are never sunk
  a_r9_no_smm_sink: assert property (@(posedge clk) disable iff (!rstN)
    sel.isBlack |-> !accSmm);

  // R4: high alias lands inside the legacy RAM window
  a_r4_alias_target: assert property (@(posedge clk) disable iff (!rstN)
    sel.isHigh |-> (ramAddr >= LOW_A && (ramAddr - LOW_A) < WIN_A));

  // R7: segment selects stay below the top of low memory
  a_r7_below_top: assert property (@(posedge clk) disable iff (!rstN)
    (sel.isTseg || sel.isBlack) |-> (accAddr < topLowMem));

endmodule

// File: rtl/smm_access_ctl.sv
module smm_access_ctl
  import smm_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned EXT_TSEG_MIB = 16,
  parameter int unsigned EXT_TSEG_MAX = 4095
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [15:0]       cfgWrData,
  output logic [15:0]       cfgRdData,
  input  logic [ADDR_W-1:0] topLowMem,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accSmm,
  output logic              selDefault,
  output logic              selLowRam,
  output logic              selHighRam,
  output logic              selTsegRam,
  output logic              selBlackhole,
  output logic [ADDR_W-1:0] ramAddr
);

  generate
    if (EXT_TSEG_MIB > EXT_TSEG_MAX) begin : g_bad_size
      $error("extended segment size exceeds the configured maximum");
    end
  endgenerate

  smmView_t view;
  smmSel_t  sel;

  smm_cfg_ctrl #(.EXT_TSEG_MIB(EXT_TSEG_MIB)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .view      (view)
  );

  smm_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk       (clk),
    .rstN      (rstN),
    .view      (view),
    .topLowMem (topLowMem),
    .accAddr   (accAddr),
    .accSmm    (accSmm),
    .sel       (sel),
    .ramAddr   (ramAddr)
  );

  assign selDefault   = sel.isDefault;
  assign selLowRam    = sel.isLow;
  assign selHighRam   = sel.isHigh;
  assign selTsegRam   = sel.isTseg;
  assign selBlackhole = sel.isBlack;

endmodule

// File: tb/smm_access_ctl_tb.sv
module smm_access_ctl_tb;

  typedef struct packed {
    logic [7:0]  ctl;
    logic [7:0]  ext;
    logic        smm;
    logic [31:0] addr;
    logic [4:0]  sel;   // {default, low, high, tseg, black}
    logic [31:0] ram;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{8'h01, 8'h00, 1'b0, 32'h000A0000, 5'b01000, 32'h000A0000}, // R3 open, low
    '{8'h01, 8'h80, 1'b0, 32'h000A0000, 5'b10000, 32'h000A0000}, // R3 high enable hides low
    '{8'h00, 8'h00, 1'b0, 32'h000BFFFF, 5'b10000, 32'h000BFFFF}, // R3 closed
    '{8'h01, 8'h00, 1'b0, 32'h000C0000, 5'b10000, 32'h000C0000}, // R3 past window end
    '{8'h01, 8'h80, 1'b0, 32'hFEDA0010, 5'b00100, 32'h000A0010}, // R4 alias
    '{8'h00, 8'h80, 1'b0, 32'hFEDA0010, 5'b10000, 32'hFEDA0010}, // R4 closed
    '{8'h08, 8'h00, 1'b1, 32'h000A0000, 5'b01000, 32'h000A0000}, // R5 smm low
    '{8'h08, 8'h80, 1'b1, 32'hFEDBFFFF, 5'b00100, 32'h000BFFFF}, // R5 smm high
    '{8'h08, 8'h80, 1'b1, 32'h000A0000, 5'b10000, 32'h000A0000}, // R5 low hidden by high enable
    '{8'h00, 8'h00, 1'b1, 32'h000A0000, 5'b10000, 32'h000A0000}, // R5 global off
    '{8'h08, 8'h01, 1'b0, 32'h07F00000, 5'b00001, 32'h07F00000}, // R6 code0 base
    '{8'h08, 8'h01, 1'b0, 32'h07EFFFFF, 5'b10000, 32'h07EFFFFF}, // R6 code0 below
    '{8'h08, 8'h03, 1'b0, 32'h07E00000, 5'b00001, 32'h07E00000}, // R6 code1 base
    '{8'h08, 8'h03, 1'b0, 32'h07DFFFFF, 5'b10000, 32'h07DFFFFF}, // R6 code1 below
    '{8'h08, 8'h05, 1'b0, 32'h07800000, 5'b00001, 32'h07800000}, // R6 code2 base
    '{8'h08, 8'h05, 1'b0, 32'h077FFFFF, 5'b10000, 32'h077FFFFF}, // R6 code2 below
    '{8'h08, 8'h07, 1'b0, 32'h07D00000, 5'b00001, 32'h07D00000}, // R6 code3 base
    '{8'h08, 8'h07, 1'b0, 32'h07CFFFFF, 5'b10000, 32'h07CFFFFF}, // R6 code3 below
    '{8'h08, 8'h01, 1'b1, 32'h07F00000, 5'b00010, 32'h07F00000}, // R7 smm reaches RAM
    '{8'h00, 8'h01, 1'b0, 32'h07F00000, 5'b10000, 32'h07F00000}, // R6 global off
    '{8'h08, 8'h00, 1'b0, 32'h07FFFFFF, 5'b10000, 32'h07FFFFFF}, // R6 segment off
    '{8'h08, 8'h01, 1'b0, 32'h08000000, 5'b10000, 32'h08000000}  // R7 top excluded
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = 2'd0;
  logic [15:0] cfgWrData = 16'h0;
  logic [15:0] cfgRdData;
  logic [31:0] topLowMem = 32'h0800_0000;
  logic [31:0] accAddr = 32'h0;
  logic        accSmm = 1'b0;
  logic        selDefault, selLowRam, selHighRam, selTsegRam, selBlackhole;
  logic [31:0] ramAddr;
  int          nRun = 0;
  int          nFail = 0;

  always #2.5 clk = ~clk;

  smm_access_ctl #(.ADDR_W(32), .EXT_TSEG_MIB(3), .EXT_TSEG_MAX(4095)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .topLowMem(topLowMem),
    .accAddr(accAddr), .accSmm(accSmm), .selDefault(selDefault),
    .selLowRam(selLowRam), .selHighRam(selHighRam), .selTsegRam(selTsegRam),
    .selBlackhole(selBlackhole), .ramAddr(ramAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdData;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  function automatic logic [4:0] selVec();
    return {selDefault, selLowRam, selHighRam, selTsegRam, selBlackhole};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    doReset();

    // R1 reset state
    readReg(2'd0, rd); check("R1 ctl", 32'(rd), 32'h00);
    readReg(2'd1, rd); check("R1 ext", 32'(rd), 32'h00);
    readReg(2'd2, rd); check("R1 size query", 32'(rd), 32'hFFFF);
    accAddr = 32'h000A0000; accSmm = 1'b1; #1;
    check("R1 default select", 32'(selVec()), 32'(5'b10000));
    accAddr = 32'h07FFFFFF; accSmm = 1'b0; #1;
    check("R1 default select top", 32'(selVec()), 32'(5'b10000));

    // table walk: R3..R7, R9
    for (int i = 0; i < NV; i++) begin
      cfgWrite(2'd0, {8'h00, VEC[i].ctl});
      cfgWrite(2'd1, {8'h00, VEC[i].ext});
      accAddr = VEC[i].addr; accSmm = VEC[i].smm; #1;
      check($sformatf("R3-7 vec%0d select", i), 32'(selVec()), 32'(VEC[i].sel));
      check($sformatf("R4 vec%0d ramAddr", i), ramAddr, VEC[i].ram);
      check($sformatf("R9 vec%0d onehot", i), 32'($countones(selVec())), 32'd1);
    end

    // R2 masks while unlocked
    cfgWrite(2'd1, 16'h00FF);
    readReg(2'd1, rd); check("R2 ext mask", 32'(rd), 32'h87);
    cfgWrite(2'd0, 16'h00F3);
    readReg(2'd0, rd); check("R2 ctl mask", 32'(rd), 32'h01);

    // R8 query and plain writes
    cfgWrite(2'd2, 16'hFFFF);
    readReg(2'd2, rd); check("R8 query answered", 32'(rd), 32'd3);
    cfgWrite(2'd2, 16'h1234);
    readReg(2'd2, rd); check("R8 plain value", 32'(rd), 32'h1234);

    // R2 lock: open forced off, registers frozen
    cfgWrite(2'd1, 16'h0000);
    cfgWrite(2'd0, 16'h000D);
    readReg(2'd0, rd); check("R2 lock clears open", 32'(rd), 32'h0C);
    accAddr = 32'h000A0000; accSmm = 1'b0; #1;
    check("R2 locked closed window", 32'(selVec()), 32'(5'b10000));
    cfgWrite(2'd0, 16'h0001);
    readReg(2'd0, rd); check("R2 ctl frozen", 32'(rd), 32'h0C);
    cfgWrite(2'd1, 16'h0081);
    readReg(2'd1, rd); check("R2 ext frozen", 32'(rd), 32'h00);
    accAddr = 32'h07F00000; #1;
    check("R2 frozen no segment", 32'(selVec()), 32'(5'b10000));
    accAddr = 32'h000A0000; accSmm = 1'b1; #1;
    check("R2 smm still sees low", 32'(selVec()), 32'(5'b01000));
    doReset();
    readReg(2'd0, rd); check("R2 reset unlocks", 32'(rd), 32'h00);
    cfgWrite(2'd0, 16'h0001);
    readReg(2'd0, rd); check("R2 writable after reset", 32'(rd), 32'h01);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule